// File: doc/BRIEF.md
# Timer Interrupt Status and Routing

This block sits between a bank of timer comparators and the interrupt lines of a chip. Each timer channel delivers a one-cycle fire strobe. For each channel the block keeps a pending status bit and produces either a held level interrupt or a one-cycle pulse. It then steers the result onto one of `N_LINES` interrupt lines, chosen by that channel's route field. Software clears pending bits by writing ones to the status port. A per-channel enable and a global enable gate the interrupt drive without affecting the status bits.

A legacy replacement mode takes two fixed lines for timers 0 and 1. In that mode it blocks the pass-through inputs from an external interval timer and a real-time clock. It also drops an enable output to the interval timer. When legacy mode is off, those two external inputs are ORed onto the same two lines. Every interface is a plain control or status pin. The block has no data streams, so it has no valid/ready handshake and never applies back-pressure.

Top module: `tmr_irq_hub`

## Requirements
- R1: When a timer whose type bit is 1 (level) fires, its status bit reads 1 after the next clock edge. If both enables are 1, its routed line goes high on that same edge and stays high until the bit is cleared.
- R2: When a timer whose type bit is 0 (edge) fires with both enables at 1, its routed line is high for exactly one cycle after the edge. Its status bit reads 0 after the edge.
- R3: A level timer whose own enable is 0 still sets its status bit when it fires, but it drives no line.
- R4: While the global enable is 0, no timer drives any line. A pending status bit keeps its value, and a held line drops on the first edge after the global enable goes low.
- R5: A status write with bit i set to 1 clears status bit i and drops the timer's line on that edge. Bits written as 0 leave their status unchanged. A fire in the same cycle takes priority over the clear.
- R6: Outside legacy mode, timer i drives line number `route[i]` (bits i*RW+RW-1 to i*RW of the route bus, RW = log2 of N_LINES).
- R7: In legacy mode, timer 0 drives line 0 and timer 1 drives line 8, whatever their route fields hold. Other timers keep using their route field.
- R8: In legacy mode, the interval-timer input does not reach line 0 and the RTC input does not reach line 8. `pit_enable` reads 0 after the next edge. When legacy mode is left, line 8 at once follows the RTC input again, and `pit_enable` returns to 1 after the next edge. `pit_enable` is 1 after reset.
- R9: When the global enable or a timer's enable rises while that level timer's status bit is set, its line is asserted again on the next edge.
- R10: When a timer's type changes from level to edge, its status bit is cleared and its line is dropped on the next edge.
- R11: Outside legacy mode, the interval-timer input is ORed onto line 0 and the RTC input onto line 8, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fire | input | N_TMR | One-cycle fire strobe per timer |
| tmr_en | input | N_TMR | Per-timer interrupt enable |
| tmr_level | input | N_TMR | Per-timer type: 1 level, 0 edge |
| tmr_route | input | N_TMR*RW | Packed per-timer line select |
| glb_en | input | 1 | Global interrupt enable |
| legacy_en | input | 1 | Legacy replacement mode |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | N_TMR | Write-one-to-clear mask |
| pit_in | input | 1 | External interval-timer interrupt |
| rtc_in | input | 1 | External RTC interrupt |
| irq_out | output | N_LINES | Interrupt lines |
| status | output | N_TMR | Pending status bits |
| pit_enable | output | 1 | Enable to the external interval timer |

## Verification
The assertions assume that every input is known after reset and changes only between clock edges. They also assume that `fire`, `sts_wr` and the configuration pins are sampled as single-cycle values at each edge. The stimulus drives all inputs one time unit after the rising edge and holds them for a full period, so each edge sees one stable set. Random cycles keep fire and status writes sparse and toggle the global enable and legacy mode only occasionally. This leaves pending bits set across enable edges and mode changes long enough for those transitions to be exercised.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  // Fixed lines taken over in legacy replacement mode
  localparam int unsigned LEGACY_LINE_T0 = 0;
  localparam int unsigned LEGACY_LINE_T1 = 8;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/tmr_irq_slice.sv
module tmr_irq_slice
  import tmr_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic tmr_en,
  input  logic is_level,
  input  logic glb_en,
  input  logic clr_req,
  output logic status_q,
  output logic irq_q
);
  logic type_prev_q;
  logic held_q;
  logic pulse_q;
  logic status_d;
  logic set_ev;
  logic clr_ev;
  logic drive_ok;
  trig_e trig;

  assign trig     = trig_e'(is_level);
  assign drive_ok = tmr_en & glb_en;
  assign set_ev   = fire & (trig == TRIG_LEVEL);
  assign clr_ev   = clr_req | (type_prev_q & (trig == TRIG_EDGE))
                  | (fire & (trig == TRIG_EDGE));

  always_comb begin
    status_d = status_q;
    if (set_ev)      status_d = 1'b1;
    else if (clr_ev) status_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q    <= 1'b0;
      held_q      <= 1'b0;
      pulse_q     <= 1'b0;
      type_prev_q <= 1'b0;
    end else begin
      status_q    <= status_d;
      held_q      <= status_d & drive_ok & (trig == TRIG_LEVEL);
      pulse_q     <= fire & drive_ok & (trig == TRIG_EDGE);
      type_prev_q <= is_level;
    end
  end

  assign irq_q = held_q | pulse_q;

  assert_level_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_level) |=> status_q);
  assert_edge_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !is_level && tmr_en && glb_en) |=> (irq_q && !status_q));
  assert_tmr_off_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_en) |=> !irq_q);
  assert_glb_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en) |=> !irq_q);
  assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !fire) |=> (!status_q && !held_q));
  assert_type_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(is_level) && !fire) |=> !status_q);
endmodule

// File: rtl/tmr_irq_router.sv
module tmr_irq_router
  import tmr_irq_pkg::*;
#(
  parameter int unsigned N_TMR   = 8,
  parameter int unsigned N_LINES = 32,
  parameter int unsigned RW      = $clog2(N_LINES)
) (
  input  logic [N_TMR-1:0]    tmr_irq,
  input  logic [N_TMR*RW-1:0] tmr_route,
  input  logic                legacy_en,
  input  logic                pit_in,
  input  logic                rtc_in,
  output logic [N_LINES-1:0]  lines
);
  logic [N_LINES-1:0] tmr_lines;
  logic [N_LINES-1:0] ext_lines;

  always_comb begin
    tmr_lines = '0;
    for (int i = 0; i < int'(N_TMR); i++) begin
      logic [RW-1:0] sel;
      sel = tmr_route[i*RW +: RW];
      if (legacy_en && i == 0)      sel = RW'(LEGACY_LINE_T0);
      else if (legacy_en && i == 1) sel = RW'(LEGACY_LINE_T1);
      if (tmr_irq[i]) tmr_lines[sel] = 1'b1;
    end
  end

  always_comb begin
    ext_lines = '0;
    if (!legacy_en) begin
      ext_lines[LEGACY_LINE_T0] = pit_in;
      ext_lines[LEGACY_LINE_T1] = rtc_in;
    end
  end

  assign lines = tmr_lines | ext_lines;
endmodule

// File: rtl/tmr_irq_hub.sv
module tmr_irq_hub
  import tmr_irq_pkg::*;
#(
  parameter int unsigned N_TMR   = 8,
  parameter int unsigned N_LINES = 32,
  parameter int unsigned RW      = $clog2(N_LINES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_TMR-1:0]    fire,
  input  logic [N_TMR-1:0]    tmr_en,
  input  logic [N_TMR-1:0]    tmr_level,
  input  logic [N_TMR*RW-1:0] tmr_route,
  input  logic                glb_en,
  input  logic                legacy_en,
  input  logic                sts_wr,
  input  logic [N_TMR-1:0]    sts_wdata,
  input  logic                pit_in,
  input  logic                rtc_in,
  output logic [N_LINES-1:0]  irq_out,
  output logic [N_TMR-1:0]    status,
  output logic                pit_enable
);
  logic [N_TMR-1:0] tmr_irq;
  logic [N_TMR-1:0] clr_mask;
  logic             pit_en_q;

  assign clr_mask = sts_wdata & {N_TMR{sts_wr}};

  for (genvar g = 0; g < int'(N_TMR); g++) begin : g_slice
    tmr_irq_slice u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire[g]),
      .tmr_en   (tmr_en[g]),
      .is_level (tmr_level[g]),
      .glb_en   (glb_en),
      .clr_req  (clr_mask[g]),
      .status_q (status[g]),
      .irq_q    (tmr_irq[g])
    );
  end

  tmr_irq_router #(.N_TMR(N_TMR), .N_LINES(N_LINES), .RW(RW)) u_router (
    .tmr_irq   (tmr_irq),
    .tmr_route (tmr_route),
    .legacy_en (legacy_en),
    .pit_in    (pit_in),
    .rtc_in    (rtc_in),
    .lines     (irq_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pit_en_q <= 1'b1;
    else        pit_en_q <= ~legacy_en;
  end
  assign pit_enable = pit_en_q;

  assert_pit_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_en |=> !pit_enable);
  assert_pit_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !legacy_en |=> pit_enable);
  assert_no_irq_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && legacy_en) |=> (tmr_irq == '0));
endmodule

// File: tb/tmr_irq_hub_tb.sv
module tmr_irq_hub_tb;
  localparam int NT = 8;
  localparam int NL = 32;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NT-1:0] fire = '0, tmr_en = '0, tmr_level = '0, sts_wdata = '0;
  logic [NT*RW-1:0] tmr_route = '0;
  logic glb_en = 1'b0, legacy_en = 1'b0, sts_wr = 1'b0, pit_in = 1'b0, rtc_in = 1'b0;
  logic [NL-1:0] irq_out;
  logic [NT-1:0] status;
  logic pit_enable;

  int n_checks = 0;
  int n_fail = 0;

  // bench model state
  logic [NT-1:0] m_st = '0, m_held = '0, m_pulse = '0, m_ptype = '0;
  logic m_pit = 1'b1;

  always #2 clk = ~clk;

  tmr_irq_hub #(.N_TMR(NT), .N_LINES(NL), .RW(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .fire(fire), .tmr_en(tmr_en), .tmr_level(tmr_level),
    .tmr_route(tmr_route), .glb_en(glb_en), .legacy_en(legacy_en), .sts_wr(sts_wr),
    .sts_wdata(sts_wdata), .pit_in(pit_in), .rtc_in(rtc_in), .irq_out(irq_out),
    .status(status), .pit_enable(pit_enable)
  );

  function automatic logic [NL-1:0] exp_lines();
    logic [NL-1:0] l = '0;
    for (int i = 0; i < NT; i++) begin
      int sel = int'(tmr_route[i*RW +: RW]);
      if (legacy_en && i == 0) sel = 0;
      if (legacy_en && i == 1) sel = 8;
      if (m_held[i] | m_pulse[i]) l[sel] = 1'b1;
    end
    if (!legacy_en) begin
      l[0] = l[0] | pit_in;
      l[8] = l[8] | rtc_in;
    end
    return l;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    for (int i = 0; i < NT; i++) begin
      logic nst;
      logic clr = (sts_wr & sts_wdata[i]) | (m_ptype[i] & ~tmr_level[i]) | (fire[i] & ~tmr_level[i]);
      nst = (fire[i] & tmr_level[i]) ? 1'b1 : (clr ? 1'b0 : m_st[i]);
      m_st[i]    = nst;
      m_held[i]  = nst & tmr_en[i] & glb_en & tmr_level[i];
      m_pulse[i] = fire[i] & ~tmr_level[i] & tmr_en[i] & glb_en;
      m_ptype[i] = tmr_level[i];
    end
    m_pit = ~legacy_en;
  endtask

  // advance one clock, then compare against model (R6 covers line selection)
  task automatic step();
    model_edge();
    @(posedge clk); #1;
    chk("R6 lines", 64'(irq_out), 64'(exp_lines()));
    chk("R5 status", 64'(status), 64'(m_st));
    chk("R8 pit_enable", 64'(pit_enable), 64'(m_pit));
    fire = '0; sts_wr = 1'b0; sts_wdata = '0;
  endtask

  task automatic set_route(input int t, input int line);
    tmr_route[t*RW +: RW] = RW'(line);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R8 reset pit_enable", 64'(pit_enable), 64'd1);
    chk("R5 reset status", 64'(status), 64'd0);
    chk("R1 reset irq", 64'(irq_out), 64'd0);

    // R1 + R6: level timer 2 on line 5
    glb_en = 1; tmr_en[2] = 1; tmr_level[2] = 1; set_route(2, 5);
    step();
    fire[2] = 1; step();
    chk("R1 status set", 64'(status[2]), 64'd1);
    chk("R6 line5", 64'(irq_out[5]), 64'd1);
    step();
    chk("R1 held", 64'(irq_out[5]), 64'd1);
    // R5: zero write ignored, one write clears
    sts_wr = 1; sts_wdata = 8'h00; step();
    chk("R5 zero write", 64'(status[2]), 64'd1);
    chk("R5 zero write line", 64'(irq_out[5]), 64'd1);
    sts_wr = 1; sts_wdata = 8'h04; step();
    chk("R5 clear", 64'(status[2]), 64'd0);
    chk("R5 line low", 64'(irq_out[5]), 64'd0);

    // R2: edge timer 3 on line 12
    tmr_en[3] = 1; tmr_level[3] = 0; set_route(3, 12);
    fire[3] = 1; step();
    chk("R2 pulse", 64'(irq_out[12]), 64'd1);
    chk("R2 status clear", 64'(status[3]), 64'd0);
    step();
    chk("R2 pulse ends", 64'(irq_out[12]), 64'd0);

    // R3 + R9: timer 4 disabled level on line 20
    tmr_en[4] = 0; tmr_level[4] = 1; set_route(4, 20);
    step();
    fire[4] = 1; step();
    chk("R3 status", 64'(status[4]), 64'd1);
    chk("R3 no line", 64'(irq_out[20]), 64'd0);
    tmr_en[4] = 1; step();
    chk("R9 timer enable rise", 64'(irq_out[20]), 64'd1);
    // R4: global off keeps status, drops line
    glb_en = 0; step();
    chk("R4 line low", 64'(irq_out[20]), 64'd0);
    chk("R4 status kept", 64'(status[4]), 64'd1);
    glb_en = 1; step();
    chk("R9 global enable rise", 64'(irq_out[20]), 64'd1);
    // R10: level -> edge
    tmr_level[4] = 0; step();
    chk("R10 status", 64'(status[4]), 64'd0);
    chk("R10 line", 64'(irq_out[20]), 64'd0);

    // R11 / R8 / R7: pass-through and legacy
    pit_in = 1; rtc_in = 1; #1;
    chk("R11 pit pass", 64'(irq_out[0]), 64'd1);
    chk("R11 rtc pass", 64'(irq_out[8]), 64'd1);
    legacy_en = 1; #1;
    chk("R8 pit masked", 64'(irq_out[0]), 64'd0);
    chk("R8 rtc masked", 64'(irq_out[8]), 64'd0);
    step();
    chk("R8 pit_enable low", 64'(pit_enable), 64'd0);
    tmr_en[1:0] = 2'b11; tmr_level[1:0] = 2'b11; set_route(0, 30); set_route(1, 31);
    fire[1:0] = 2'b11; step();
    chk("R7 timer0 line0", 64'(irq_out[0]), 64'd1);
    chk("R7 timer1 line8", 64'(irq_out[8]), 64'd1);
    chk("R7 route ignored", 64'(irq_out[31:30]), 64'd0);
    sts_wr = 1; sts_wdata = 8'h03; step();
    legacy_en = 0; rtc_in = 1; pit_in = 0; #1;
    chk("R8 rtc restored", 64'(irq_out[8]), 64'd1);
    step();
    chk("R8 pit_enable back", 64'(pit_enable), 64'd1);

    // constrained random
    for (int c = 0; c < 3000; c++) begin
      fire      = NT'($urandom) & NT'($urandom) & NT'($urandom);
      if (($urandom % 8) == 0) tmr_en = NT'($urandom);
      if (($urandom % 16) == 0) tmr_level = NT'($urandom);
      if (($urandom % 32) == 0) tmr_route = (NT*RW)'({$urandom, $urandom});
      if (($urandom % 20) == 0) glb_en = ~glb_en;
      if (($urandom % 40) == 0) legacy_en = ~legacy_en;
      sts_wr    = (($urandom % 6) == 0);
      sts_wdata = NT'($urandom);
      pit_in    = ($urandom % 4) == 0;
      rtc_in    = ($urandom % 4) == 0;
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule